// File: doc/BRIEF.md
# Printer Port Controller with Internal Handshake

This block is a byte-wide printer port reached through a small register bus. A host sees three registers: a data byte, a status byte and a control byte. The printer side of the handshake is emulated inside the block, so no external printer timing is needed. Software writes a byte to the data register and then raises the strobe bit in control, with select and init held high. The byte then leaves on a one-cycle output stream. Software polls status to watch the emulated busy and acknowledge lines step through their sequence.

A level interrupt output can be armed through an interrupt-enable control bit. It is raised by a control write that drops strobe while select and init are high. Reading status clears it. When the direction bit of control is set, a data read returns a loopback input byte instead of the last written byte. Offsets 3 to 7 of the 3-bit register space are unused.

The busy and acknowledge bits form a small state machine with three live states:
- HS_READY: busy and ack both 1. This is the reset state and the state after an init load.
- HS_TAKEN: busy 0, ack 1.
- HS_ACKED: busy 0, ack 0.

Its transitions are:
- TAKE: HS_READY goes to HS_TAKEN on a strobe-high control write.
- ACK_DROP: HS_TAKEN goes to HS_ACKED on a status read while the stored strobe bit is 0.
- RELOAD: HS_ACKED goes to HS_READY on a status read while the stored strobe bit is 0.
- INIT: any state goes to HS_READY on a control write with init low.

Top module: `prn_port`

## Requirements
- R1: Offset 0 is data, 1 is status and 2 is control. A read of offset 3 to 7 returns 0xFF, and a write to those offsets changes no register, interrupt or output.
- R2: A control write stores the written value with bits 7 and 6 forced to 1. Reading control returns that stored value.
- R3: A control write with init (bit 2) at 0 sets status to 0xD8. This clears the timeout bit (bit 0) and sets busy (bit 7) and ack (bit 6).
- R4: A control write with init (bit 2), select (bit 3) and strobe (bit 0) all at 1 clears status busy. If the stored strobe bit was 0 before the write, `out_valid` is high in the next cycle with `out_byte` equal to the data register.
- R5: A control write with init 1, select 1 and strobe 0 raises `irq` in the next cycle, but only if the stored interrupt-enable bit (bit 4) was 1 before the write.
- R6: A data read returns `in_byte` when control bit 5 is 1, and otherwise returns the last byte written to data.
- R7: A status read returns the current status and drops `irq` in the next cycle.
- R8: A status read with busy 0 and stored strobe 0 steps the handshake. If ack was 1, ack clears. If ack was 0, both ack and busy are set. Status bits 5, 2 and 1 always read 0, and bits 4 and 3 always read 1.
- R9: After reset, data reads 0xFF, status reads 0xD9, control reads 0xCC and `irq` is 0.
- R10: `out_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe; takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe; side effects take place at the edge, and it is ignored while bus_wr is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| in_byte | input | 8 | Loopback input byte |
| irq | output | 1 | Level interrupt |
| out_valid | output | 1 | One-cycle byte emit strobe |
| out_byte | output | 8 | Emitted byte |

## Verification
The bench aims at the edge of the strobe bit. A design that emits on any strobe-high write, instead of only on a 0-to-1 change, would send duplicate bytes. The bench also checks that the interrupt condition uses the enable bit stored before the write; a design that used the newly written bit would raise `irq` on the wrong writes. Status-read stepping is checked with the stored strobe both high and low, because getting that condition wrong leaves busy stuck or cycling. Writes and reads at offsets 3 to 7 and direction-bit data reads are mixed into a long run of random traffic to catch decode and multiplexer faults.

// File: rtl/prn_pkg.sv
package prn_pkg;
    localparam int OFS_W  = 3;
    localparam int BYTE_W = 8;

    localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
    localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

    // control bit positions
    localparam int CB_STROBE = 0;
    localparam int CB_INIT   = 2;
    localparam int CB_SELECT = 3;
    localparam int CB_INTEN  = 4;
    localparam int CB_DIR    = 5;

    localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
    localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
    localparam logic [BYTE_W-1:0] BYTE_ONES  = 8'hFF;

    // encoding is {busy, ack}
    typedef enum logic [1:0] {
        HS_ACKED = 2'b00,
        HS_TAKEN = 2'b01,
        HS_RSVD  = 2'b10,
        HS_READY = 2'b11
    } hs_state_t;
endpackage

// File: rtl/prn_hs_fsm.sv
module prn_hs_fsm
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_load,
    input  logic              strobe_take,
    input  logic              stat_rd,
    input  logic              ctrl_strobe,
    output logic [BYTE_W-1:0] status
);
    hs_state_t state_q, state_d;
    logic      tmo_q;
    logic      step;

    assign step = stat_rd && !ctrl_strobe;

    always_comb begin
        state_d = state_q;
        if (init_load) begin
            state_d = HS_READY;                       // INIT
        end else begin
            unique case (state_q)
                HS_READY: if (strobe_take) state_d = HS_TAKEN;  // TAKE
                HS_TAKEN: if (step)        state_d = HS_ACKED;  // ACK_DROP
                HS_ACKED: if (step)        state_d = HS_READY;  // RELOAD
                default:                   state_d = HS_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_READY;
            tmo_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            if (init_load) tmo_q <= 1'b0;
        end
    end

    always_comb begin
        status = {state_q, 1'b0, 1'b1, 1'b1, 2'b00, tmo_q};
    end

    p_init_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_load |=> (status == 8'hD8));

    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init_load && state_q == HS_ACKED) |=> (status[7:6] == 2'b11));

    p_no_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != HS_RSVD);
endmodule

// File: rtl/prn_ctrl_regs.sv
module prn_ctrl_regs
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic              wr_ctrl,
    input  logic              stat_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] data_q,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic              init_load,
    output logic              strobe_take,
    output logic              irq,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);
    logic [BYTE_W-1:0] wval;
    logic              sel_ok, emit, irq_set;

    always_comb begin
        wval        = wdata | CTRL_FORCE;
        init_load   = wr_ctrl && !wval[CB_INIT];
        sel_ok      = wr_ctrl && wval[CB_INIT] && wval[CB_SELECT];
        strobe_take = sel_ok && wval[CB_STROBE];
        emit        = strobe_take && !ctrl_q[CB_STROBE];
        irq_set     = sel_ok && !wval[CB_STROBE] && ctrl_q[CB_INTEN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q    <= BYTE_ONES;
            ctrl_q    <= CTRL_RST;
            irq       <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= BYTE_ONES;
        end else begin
            out_valid <= emit;
            if (emit)    out_byte <= data_q;
            if (wr_data) data_q   <= wdata;
            if (wr_ctrl) ctrl_q   <= wval;
            if (stat_rd)      irq <= 1'b0;
            else if (irq_set) irq <= 1'b1;
        end
    end

    p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl_q[7:6] == 2'b11 && ctrl_q[5:0] == $past(wdata[5:0])));

    p_emit_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ctrl_q[CB_STROBE] && !$past(ctrl_q[CB_STROBE])));

    p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctrl_q[CB_INTEN]));

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !irq);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: rtl/prn_port.sv
module prn_port
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              irq,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);
    logic              wr_data, wr_ctrl, stat_rd;
    logic              init_load, strobe_take;
    logic [BYTE_W-1:0] data_q, ctrl_q, status;

    assign wr_data = bus_wr && (bus_addr == OFS_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign stat_rd = bus_rd && !bus_wr && (bus_addr == OFS_STAT);

    prn_ctrl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_data     (wr_data),
        .wr_ctrl     (wr_ctrl),
        .stat_rd     (stat_rd),
        .wdata       (bus_wdata),
        .data_q      (data_q),
        .ctrl_q      (ctrl_q),
        .init_load   (init_load),
        .strobe_take (strobe_take),
        .irq         (irq),
        .out_valid   (out_valid),
        .out_byte    (out_byte)
    );

    prn_hs_fsm u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_load   (init_load),
        .strobe_take (strobe_take),
        .stat_rd     (stat_rd),
        .ctrl_strobe (ctrl_q[CB_STROBE]),
        .status      (status)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = ctrl_q[CB_DIR] ? in_byte : data_q;
            OFS_STAT: bus_rdata = status;
            OFS_CTRL: bus_rdata = ctrl_q;
            default:  bus_rdata = BYTE_ONES;
        endcase
    end

    p_oob_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr > OFS_CTRL) |=> ($stable(status) && $stable(irq) && !out_valid));
endmodule

// File: tb/prn_port_test.sv
`timescale 1ns/1ps
module prn_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, in_byte = '0;
    logic [7:0] bus_rdata, out_byte;
    logic       irq, out_valid;

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_data, m_ctrl;
    logic       m_busy, m_ack, m_tmo, m_irq;

    always #5 clk = ~clk;

    prn_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_byte(in_byte), .irq(irq), .out_valid(out_valid), .out_byte(out_byte)
    );

    function automatic logic [7:0] m_status();
        return {m_busy, m_ack, 1'b0, 1'b1, 1'b1, 2'b00, m_tmo};
    endfunction

    function automatic logic [7:0] m_read(logic [2:0] a, logic [7:0] inb);
        case (a)
            3'd0:    return m_ctrl[5] ? inb : m_data;
            3'd1:    return m_status();
            3'd2:    return m_ctrl;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_op(bit is_wr, logic [2:0] a, logic [7:0] wd, string tag);
        logic [7:0] v;
        bit         emit;
        logic [7:0] emit_byte;
        @(negedge clk);
        bus_addr = a; bus_wr = is_wr; bus_rd = !is_wr; bus_wdata = wd;
        #1;
        if (!is_wr) check(tag, bus_rdata, m_read(a, in_byte));
        emit = 0; emit_byte = m_data;
        if (is_wr) begin
            if (a == 3'd0) m_data = wd;
            else if (a == 3'd2) begin
                v = wd | 8'hC0;
                if (!v[2]) begin
                    m_busy = 1; m_ack = 1; m_tmo = 0;
                end else if (v[3]) begin
                    if (v[0]) begin
                        m_busy = 0;
                        if (!m_ctrl[0]) emit = 1;
                    end else if (m_ctrl[4]) m_irq = 1;
                end
                m_ctrl = v;
            end
        end else if (a == 3'd1) begin
            m_irq = 0;
            if (!m_busy && !m_ctrl[0]) begin
                if (m_ack) m_ack = 0;
                else begin m_ack = 1; m_busy = 1; end
            end
        end
        @(posedge clk); #1;
        bus_wr = 0; bus_rd = 0;
        check("R5 irq level", {7'd0, irq}, {7'd0, m_irq});
        check(emit ? "R4 emit valid" : "R10 no emit", {7'd0, out_valid}, {7'd0, emit});
        if (emit) check("R4 emit byte", out_byte, emit_byte);
    endtask

    initial begin
        m_data = 8'hFF; m_ctrl = 8'hCC; m_busy = 1; m_ack = 1; m_tmo = 1; m_irq = 0;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state R9
        bus_op(0, 3'd0, 0, "R9 data reset");
        bus_op(0, 3'd2, 0, "R9 ctrl reset");
        check("R9 irq reset", {7'd0, irq}, 8'd0);
        bus_op(0, 3'd1, 0, "R9 status reset");
        // directed sequence
        bus_op(1, 3'd0, 8'h5A, "");
        bus_op(1, 3'd2, 8'h1C, "");          // inten,select,init; prior inten 0 -> no irq (R5)
        bus_op(0, 3'd2, 0, "R2 ctrl forced bits");
        bus_op(1, 3'd2, 8'h1D, "");          // strobe rise: emit 5A (R4)
        bus_op(1, 3'd2, 8'h1D, "");          // strobe held: no emit (R4)
        bus_op(0, 3'd1, 0, "R8 status busy cleared");
        bus_op(1, 3'd2, 8'h1C, "");          // strobe low with inten -> irq (R5)
        bus_op(0, 3'd1, 0, "R7 status read clears irq");
        bus_op(0, 3'd1, 0, "R8 step ack drop");
        bus_op(0, 3'd1, 0, "R8 step reload");
        bus_op(1, 3'd5, 8'h00, "");          // out-of-range write ignored (R1)
        bus_op(0, 3'd6, 0, "R1 oob read");
        bus_op(1, 3'd2, 8'h38, "");          // init low -> D8 (R3)
        bus_op(0, 3'd1, 0, "R3 init load status");
        in_byte = 8'hA3;
        bus_op(0, 3'd0, 0, "R6 loopback read");
        bus_op(1, 3'd2, 8'h0C, "");
        bus_op(0, 3'd0, 0, "R6 written data read");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] a;
            logic [7:0] wd;
            int sel;
            in_byte = 8'($urandom);
            sel = int'($urandom_range(0, 9));
            wd  = 8'($urandom);
            if (sel < 4) begin
                if ($urandom_range(0, 9) < 8) wd[3:2] = 2'b11;
                bus_op(1, 3'd2, wd, "");
            end else if (sel < 5) begin
                bus_op(1, 3'($urandom), wd, "");
            end else begin
                a = 3'($urandom);
                if (sel < 8) a = 3'd1;
                case (a)
                    3'd0:    bus_op(0, a, 0, "R6 random data read");
                    3'd1:    bus_op(0, a, 0, "R8 random status read");
                    3'd2:    bus_op(0, a, 0, "R2 random ctrl read");
                    default: bus_op(0, a, 0, "R1 random oob read");
                endcase
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule